// File: doc/BRIEF.md
# Double-Buffered Parallel DAC Register Front End

This block is a clock-synchronous model of the digital side of an 8-bit parallel-input voltage converter. A host drives a data bus and four active-low strobes: a select, a write, a transfer and a zero strobe. All of them are sampled by a fast system clock. Two registers sit in series. The input register takes the bus, and the output register takes the input register. Only the output register drives the code that sets the analog level. Each register is level-controlled and stays open for as long as its strobe pair is held low. This lets a host load several converters and then update them together, or hold every strobe low to make the whole path transparent.

The block also watches the strobe timing. It raises sticky flags for low pulses that are too short, for bus data that is not stable long enough before the write strobe rises, and for data that changes too soon after it rises. The nanosecond limits are turned into clock-cycle counts at elaboration time, rounding up. A separate input clears the flags.

Top module: `pdac_frontend`

## Requirements
- R1: While `rst` is high (synchronous, active high), `dac_code` and `viol_flags` are forced to zero.
- R2: With `sel_n` and `strobe_n` both low, the input register follows `bus_d`. The value it holds when `strobe_n` rises is kept, and later bus changes do not reach it.
- R3: With `xfer_n` and `strobe_n` both low, the output register copies the input register. Loading the input register while `xfer_n` is high leaves `dac_code` unchanged.
- R4: A `strobe_n` pulse while both `sel_n` and `xfer_n` are high changes neither register.
- R5: With `sel_n`, `xfer_n` and `strobe_n` all held low, `dac_code` equals `bus_d` sampled four clock edges earlier. Every strobe and the bus pass through a two-flop synchronizer before use.
- R6: While the synchronized `zero_n` is low, both registers clear to 0x00, overriding every other strobe.
- R7: The code is straight binary with bit 7 as the MSB. The bus value reaches `dac_code` bit for bit, so 0x80 means half scale and 0xFF means 255/256.
- R8: A `strobe_n` low pulse shorter than the pulse limit (23 cycles at the defaults) sets `viol_flags[0]`. A pulse of exactly 23 cycles does not.
- R9: A `sel_n` or `xfer_n` low pulse shorter than the pulse limit sets `viol_flags[1]`.
- R10: A `zero_n` low pulse shorter than the pulse limit sets `viol_flags[2]`.
- R11: When `strobe_n` rises with `sel_n` low, and the bus has held its value for fewer than the setup limit (23 cycles) before the rise, `viol_flags[3]` is set.
- R12: When the bus changes within the hold limit (3 cycles, counting the rise cycle) after such a rise, `viol_flags[4]` is set. A change 3 cycles after the rise is legal.
- R13: Flags are sticky until `flag_clr` is high for a cycle. A new event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high block reset |
| bus_d | input | 8 | Parallel code bus, bit 7 is the MSB |
| sel_n | input | 1 | Input register select, active low |
| strobe_n | input | 1 | Write strobe, active low, data captured on its rise |
| xfer_n | input | 1 | Output register transfer, active low |
| zero_n | input | 1 | Clears both registers while low |
| flag_clr | input | 1 | Clears the sticky timing flags |
| dac_code | output | 8 | Output register contents, the converter code |
| viol_flags | output | 5 | Sticky flags: [0] write short, [1] select/transfer short, [2] zero short, [3] setup, [4] hold |

## Verification
Any input change first spends two edges in the synchronizer. The input register then loads on the third edge and `dac_code` on the fourth. A flag is set on the third edge after the strobe edge that reveals the violation. The bench drives inputs on falling edges. It waits at least six further cycles after the last change of a scenario and only then samples `dac_code` and `viol_flags`, so every result is already settled when it is read. Pulse, setup and hold lengths are counted in whole clock cycles at the bench. This puts the 22/23-cycle and 2/3-cycle boundaries exactly where the requirements place them.

// File: rtl/pdac_pkg.sv
package pdac_pkg;
  localparam int VB_WR    = 0;
  localparam int VB_SEL   = 1;
  localparam int VB_ZERO  = 2;
  localparam int VB_SETUP = 3;
  localparam int VB_HOLD  = 4;
  localparam int NVIOL    = 5;

  function automatic int ps_to_cyc(input int ps, input int clk_ps);
    return (ps + clk_ps - 1) / clk_ps;
  endfunction
endpackage

// File: rtl/pdac_sync2.sv
module pdac_sync2 #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/pdac_regpair.sv
module pdac_regpair #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] d_a,
  input  logic          sel_a,
  input  logic          strobe_a,
  input  logic          xfer_a,
  input  logic          zero_a,
  output logic [DW-1:0] code
);
  logic [DW-1:0] in_r;

  always_ff @(posedge clk) begin
    if (rst || !zero_a) begin
      in_r <= '0;
      code <= '0;
    end else begin
      if (!sel_a && !strobe_a)  in_r <= d_a;
      if (!xfer_a && !strobe_a) code <= in_r;
    end
  end
endmodule

// File: rtl/pdac_low_meter.sv
module pdac_low_meter #(
  parameter int MIN_CYC = 23
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic short_o
);
  localparam int CW = $clog2(MIN_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(MIN_CYC);

  logic [CW-1:0] cnt;
  logic          lvl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      lvl_q <= 1'b1;
    end else begin
      lvl_q <= lvl;
      if (lvl)              cnt <= '0;
      else if (cnt != LIMIT) cnt <= cnt + 1'b1;
    end
  end

  assign short_o = lvl && !lvl_q && (cnt < LIMIT);
endmodule

// File: rtl/pdac_timing_mon.sv
module pdac_timing_mon
  import pdac_pkg::*;
#(
  parameter int DW        = 8,
  parameter int PULSE_CYC = 23,
  parameter int SETUP_CYC = 23,
  parameter int HOLD_CYC  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DW-1:0]    d_a,
  input  logic             sel_a,
  input  logic             strobe_a,
  input  logic             xfer_a,
  input  logic             zero_a,
  input  logic             flag_clr,
  output logic [NVIOL-1:0] flags
);
  localparam int SW = $clog2(SETUP_CYC + 1);
  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam logic [SW-1:0] S_LIM = SW'(SETUP_CYC);
  localparam logic [HW-1:0] H_RLD = HW'(HOLD_CYC - 1);

  // pulse meters: 0 strobe, 1 select, 2 transfer, 3 zero
  logic [3:0] lvl_vec, short_vec;
  assign lvl_vec = {zero_a, xfer_a, sel_a, strobe_a};

  for (genvar i = 0; i < 4; i++) begin : g_meter
    pdac_low_meter #(.MIN_CYC(PULSE_CYC)) u_meter (
      .clk(clk), .rst(rst), .lvl(lvl_vec[i]), .short_o(short_vec[i])
    );
  end

  logic          strobe_q, sel_q;
  logic [DW-1:0] data_q, hold_val;
  logic [SW-1:0] run;
  logic [HW-1:0] hold_left;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q <= 1'b1;
      sel_q    <= 1'b1;
      data_q   <= '0;
      run      <= '0;
    end else begin
      strobe_q <= strobe_a;
      sel_q    <= sel_a;
      data_q   <= d_a;
      if (d_a != data_q)   run <= SW'(1);
      else if (run != S_LIM) run <= run + 1'b1;
    end
  end

  logic armed, setup_evt, hold_evt;
  assign armed     = strobe_a && !strobe_q && !sel_q;
  assign setup_evt = armed && (run < S_LIM);
  assign hold_evt  = (armed && (d_a != data_q)) ||
                     ((hold_left != '0) && (d_a != hold_val));

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_left <= '0;
      hold_val  <= '0;
    end else if (armed) begin
      hold_left <= H_RLD;
      hold_val  <= data_q;
    end else if (hold_left != '0) begin
      hold_left <= hold_left - 1'b1;
    end
  end

  logic [NVIOL-1:0] events;
  always_comb begin
    events           = '0;
    events[VB_WR]    = short_vec[0];
    events[VB_SEL]   = short_vec[1] | short_vec[2];
    events[VB_ZERO]  = short_vec[3];
    events[VB_SETUP] = setup_evt;
    events[VB_HOLD]  = hold_evt;
  end

  always_ff @(posedge clk) begin
    if (rst)           flags <= '0;
    else if (flag_clr) flags <= events;
    else               flags <= flags | events;
  end
endmodule

// File: rtl/pdac_frontend.sv
module pdac_frontend
  import pdac_pkg::*;
#(
  parameter int DW       = 8,
  parameter int CLK_PS   = 4000,
  parameter int PULSE_PS = 90000,
  parameter int SETUP_PS = 90000,
  parameter int HOLD_PS  = 10000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DW-1:0]    bus_d,
  input  logic             sel_n,
  input  logic             strobe_n,
  input  logic             xfer_n,
  input  logic             zero_n,
  input  logic             flag_clr,
  output logic [DW-1:0]    dac_code,
  output logic [NVIOL-1:0] viol_flags
);
  localparam int PULSE_CYC = ps_to_cyc(PULSE_PS, CLK_PS);
  localparam int SETUP_CYC = ps_to_cyc(SETUP_PS, CLK_PS);
  localparam int HOLD_CYC  = ps_to_cyc(HOLD_PS, CLK_PS);

  logic [3:0]    ctl_a;
  logic [DW-1:0] d_a;

  pdac_sync2 #(.W(4), .RST_VAL(4'hF)) u_ctl_sync (
    .clk(clk), .rst(rst), .d({zero_n, xfer_n, strobe_n, sel_n}), .q(ctl_a)
  );

  pdac_sync2 #(.W(DW), .RST_VAL('0)) u_bus_sync (
    .clk(clk), .rst(rst), .d(bus_d), .q(d_a)
  );

  pdac_regpair #(.DW(DW)) u_regs (
    .clk(clk), .rst(rst), .d_a(d_a),
    .sel_a(ctl_a[0]), .strobe_a(ctl_a[1]), .xfer_a(ctl_a[2]), .zero_a(ctl_a[3]),
    .code(dac_code)
  );

  pdac_timing_mon #(
    .DW(DW), .PULSE_CYC(PULSE_CYC), .SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC)
  ) u_mon (
    .clk(clk), .rst(rst), .d_a(d_a),
    .sel_a(ctl_a[0]), .strobe_a(ctl_a[1]), .xfer_a(ctl_a[2]), .zero_a(ctl_a[3]),
    .flag_clr(flag_clr), .flags(viol_flags)
  );
endmodule

// File: rtl/pdac_frontend_chk.sv
module pdac_frontend_chk #(
  parameter int DW = 8,
  parameter int NV = 5
) (
  input logic          clk,
  input logic          rst,
  input logic [DW-1:0] bus_d,
  input logic          sel_n,
  input logic          strobe_n,
  input logic          xfer_n,
  input logic          zero_n,
  input logic          flag_clr,
  input logic [DW-1:0] dac_code,
  input logic [NV-1:0] viol_flags
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (dac_code == '0 && viol_flags == '0));

  // R3
  dac_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(zero_n, 3) && ($past(xfer_n, 3) || $past(strobe_n, 3)))
    |-> $stable(dac_code));

  // R5
  pass_through_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst, 1) && !$past(rst, 2) && !$past(rst, 3) && !$past(rst, 4) &&
     $past(zero_n, 3) && $past(zero_n, 4) &&
     !$past(xfer_n, 3) && !$past(strobe_n, 3) &&
     !$past(sel_n, 4) && !$past(strobe_n, 4))
    |-> (dac_code == $past(bus_d, 4)));

  // R6
  zero_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(zero_n, 1) && !$past(zero_n, 2) && !$past(zero_n, 3))
    |-> (dac_code == '0));

  // R13
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(flag_clr))
    |-> ((viol_flags & $past(viol_flags)) == $past(viol_flags)));
endmodule

bind pdac_frontend pdac_frontend_chk #(.DW(DW), .NV(5)) u_chk (.*);

// File: tb/pdac_frontend_tb.sv
module pdac_frontend_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_d = 8'h00;
  logic       sel_n = 1'b1, strobe_n = 1'b1, xfer_n = 1'b1, zero_n = 1'b1;
  logic       flag_clr = 1'b0;
  logic [7:0] dac_code;
  logic [4:0] viol_flags;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2ns clk = ~clk;

  pdac_frontend u_dut (
    .clk(clk), .rst(rst), .bus_d(bus_d), .sel_n(sel_n), .strobe_n(strobe_n),
    .xfer_n(xfer_n), .zero_n(zero_n), .flag_clr(flag_clr),
    .dac_code(dac_code), .viol_flags(viol_flags)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_code(input string req, input logic [7:0] exp);
    checks++;
    if (dac_code !== exp) begin
      errors++;
      $display("FAIL %s: dac_code actual %h expected %h", req, dac_code, exp);
    end
  endtask

  task automatic chk_flags(input string req, input logic [4:0] exp);
    checks++;
    if (viol_flags !== exp) begin
      errors++;
      $display("FAIL %s: viol_flags actual %b expected %b", req, viol_flags, exp);
    end
  endtask

  task automatic clear_flags();
    flag_clr = 1'b1;
    tick(1);
    flag_clr = 1'b0;
    tick(2);
  endtask

  // strobe low for lo cycles; bus gets d su cycles before the rise; bus flips hd cycles after it
  task automatic wr_pulse(input logic [7:0] d, input bit use_sel, input bit use_xfer,
                          input int lo, input int su, input int hd);
    sel_n    = !use_sel;
    xfer_n   = !use_xfer;
    strobe_n = 1'b0;
    tick(lo - su);
    bus_d = d;
    tick(su);
    strobe_n = 1'b1;
    tick(hd);
    bus_d = ~d;
    tick(1);
    sel_n  = 1'b1;
    xfer_n = 1'b1;
    tick(8);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    tick(5);
    rst = 1'b0;
    tick(2);
    chk_code("R1", 8'h00);
    chk_flags("R1", 5'b00000);
  endtask

  task automatic t_basic_write();
    wr_pulse(8'hA5, 1, 1, 30, 30, 5);
    chk_code("R2", 8'hA5);
    chk_flags("R2 no flags", 5'b00000);
  endtask

  task automatic t_two_step();
    wr_pulse(8'h3C, 1, 0, 30, 30, 5);
    chk_code("R3 input only", 8'hA5);
    wr_pulse(8'hEE, 0, 1, 30, 30, 5);
    chk_code("R3 transfer", 8'h3C);
    chk_flags("R3 no flags", 5'b00000);
  endtask

  task automatic t_no_select();
    wr_pulse(8'h77, 0, 0, 30, 30, 5);
    chk_code("R4 ignored", 8'h3C);
    wr_pulse(8'h00, 0, 1, 30, 30, 5);
    chk_code("R4 input reg kept", 8'h3C);
  endtask

  task automatic t_transparent();
    sel_n = 1'b0; xfer_n = 1'b0; strobe_n = 1'b0;
    bus_d = 8'h11; tick(6); chk_code("R5", 8'h11);
    bus_d = 8'h80; tick(6); chk_code("R7 half scale", 8'h80);
    bus_d = 8'h01; tick(6); chk_code("R7 lsb", 8'h01);
    bus_d = 8'hFF; tick(30); chk_code("R7 full", 8'hFF);
    strobe_n = 1'b1; tick(5);
    sel_n = 1'b1; xfer_n = 1'b1;
    bus_d = 8'h12; tick(8);
    chk_code("R2 latched", 8'hFF);
    chk_flags("R5 no flags", 5'b00000);
  endtask

  task automatic t_zero_priority();
    sel_n = 1'b0; xfer_n = 1'b0; strobe_n = 1'b0;
    bus_d = 8'hA5; tick(30);
    chk_code("R5", 8'hA5);
    zero_n = 1'b0; tick(30);
    chk_code("R6 priority", 8'h00);
    zero_n = 1'b1; tick(6);
    chk_code("R6 release", 8'hA5);
    strobe_n = 1'b1; tick(5);
    sel_n = 1'b1; xfer_n = 1'b1; tick(8);
    chk_flags("R6 no flags", 5'b00000);
  endtask

  task automatic t_short_write();
    wr_pulse(8'h42, 1, 1, 22, 22, 5);
    chk_code("R8", 8'h42);
    chk_flags("R8 short write", 5'b01001);
    clear_flags();
    chk_flags("R13 clear", 5'b00000);
    wr_pulse(8'h43, 1, 1, 23, 23, 5);
    chk_flags("R8 boundary", 5'b00000);
    chk_code("R8 boundary data", 8'h43);
  endtask

  task automatic t_short_sel();
    sel_n = 1'b0; tick(5); sel_n = 1'b1; tick(8);
    chk_flags("R9 select", 5'b00010);
    clear_flags();
    xfer_n = 1'b0; tick(5); xfer_n = 1'b1; tick(8);
    chk_flags("R9 transfer", 5'b00010);
    clear_flags();
    chk_code("R9 code kept", 8'h43);
  endtask

  task automatic t_short_zero();
    zero_n = 1'b0; tick(5); zero_n = 1'b1; tick(8);
    chk_flags("R10", 5'b00100);
    chk_code("R6 short clear", 8'h00);
    clear_flags();
  endtask

  task automatic t_setup();
    wr_pulse(8'h9C, 1, 1, 30, 5, 5);
    chk_flags("R11", 5'b01000);
    chk_code("R11 data", 8'h9C);
    wr_pulse(8'h9D, 1, 1, 30, 30, 5);
    chk_flags("R13 sticky", 5'b01000);
    clear_flags();
  endtask

  task automatic t_hold();
    wr_pulse(8'h6E, 1, 1, 30, 30, 1);
    chk_flags("R12", 5'b10000);
    chk_code("R12 data", 8'h6E);
    clear_flags();
    wr_pulse(8'h6F, 1, 1, 30, 30, 3);
    chk_flags("R12 boundary", 5'b00000);
    wr_pulse(8'h70, 1, 1, 30, 30, 0);
    chk_flags("R12 same cycle", 5'b10000);
    chk_code("R12 same cycle data", 8'h70);
    clear_flags();
  endtask

  initial begin
    tick(1);
    t_reset();
    t_basic_write();
    t_two_step();
    t_no_select();
    t_transparent();
    t_zero_priority();
    t_short_write();
    t_short_sel();
    t_short_zero();
    t_setup();
    t_hold();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #400us;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule